// File: doc/BRIEF.md
# Indexed CMOS Register Port

This block is a byte-wide register window of two locations. A write to offset 0 stores an 8-bit index. A read of offset 0 returns that index. An access at offset 1 reaches the register the index selects. The block routes it by index value. Indices 0x00 to 0x0D go out to an external real-time-clock block over a plain register interface. Indices from 0x0E up to the register count minus one go to an internal byte array, which acts as battery-backed storage.

Each bus cycle that carries a strobe is classified into one access kind. The access kinds are `ACC_IDX_RD`, `ACC_IDX_WR`, `ACC_RTC_RD`, `ACC_RTC_WR`, `ACC_NV_RD`, `ACC_NV_WR` and `ACC_FAULT`. A cycle without a strobe is `ACC_IDLE`. At every clock edge the state register takes the kind of that cycle, so any state may follow any other. The output process decodes this state. The read states present the byte captured at the same edge. `ACC_FAULT` raises the error flag. All other states drive zero with no error. Only byte accesses are legal. A wider access is faulted, and so is an unknown offset, an index beyond the register count, or a read and a write in the same cycle. A faulted access changes nothing.

Top module: `cmos_port`

## Requirements
- R1: An access with `bus_size` other than 0 (0 encodes one byte) raises `bus_err` in the next cycle. It changes neither the index nor any register.
- R2: A byte write at offset 0 loads the index with `bus_wdata`. Accesses at offset 1 leave the index unchanged, so repeated data accesses reach the same register.
- R3: A byte read at offset 0 returns the current index on `bus_rdata` in the next cycle, with `bus_err` low.
- R4: For indices 0x00 to 0x0D, a data write pulses `rtc_wr` in the same cycle, with `rtc_idx` equal to the index and `rtc_wdata` equal to `bus_wdata`. A data read returns the `rtc_rdata` sampled in the strobe cycle, one cycle later. Local storage is not touched.
- R5: For indices 0x0E up to REG_COUNT-1, data writes store into local storage. Data reads return the stored byte one cycle after the strobe.
- R6: Any access at offset 2 or above raises `bus_err` in the next cycle. It has no effect.
- R7: A data access with index at or above REG_COUNT raises `bus_err`, returns 0 and writes nothing.
- R8: A cycle with both `bus_rd` and `bus_wr` raises `bus_err` in the next cycle. It has no effect.
- R9: After reset the index is 0, all local storage reads 0, and `bus_rdata` and `bus_err` are 0.
- R10: The cycle after a cycle with no strobe shows `bus_err` low and `bus_rdata` 0. A faulted access also returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_off | input | OFF_W | Window offset |
| bus_size | input | SIZE_W | Access width code, 0 = one byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the read strobe |
| bus_err | output | 1 | Error flag for the previous cycle's access |
| rtc_idx | output | 8 | Current index toward the clock block |
| rtc_rdata | input | 8 | Register value from the clock block |
| rtc_wdata | output | 8 | Write data toward the clock block |
| rtc_wr | output | 1 | Write strobe toward the clock block |

## Verification
Two functions can land in the same cycle. The first is an index rewrite. The second is a data access placed on the very next cycle, which must already use the new index. The bench issues the two strobes back to back with no gap. It then checks that the returned byte belongs to the newly selected register. Simultaneous read and write strobes are also driven, at both offsets. The index and the stored data are then read back through the window, to show that neither write took effect.

// File: rtl/cmos_port_pkg.sv
package cmos_port_pkg;
    localparam int unsigned DATA_W       = 8;
    localparam int unsigned RTC_LAST_IDX = 13;
    localparam int unsigned NV_BASE      = RTC_LAST_IDX + 1;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_IDX_RD,
        ACC_IDX_WR,
        ACC_RTC_RD,
        ACC_RTC_WR,
        ACC_NV_RD,
        ACC_NV_WR,
        ACC_FAULT
    } acc_e;
endpackage

// File: rtl/cmos_decode.sv
module cmos_decode
    import cmos_port_pkg::*;
#(
    parameter int unsigned OFF_W     = 2,
    parameter int unsigned SIZE_W    = 2,
    parameter int unsigned REG_COUNT = 128
) (
    input  logic              rd,
    input  logic              wr,
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    input  logic [7:0]        idx,
    output acc_e              kind
);
    logic in_range;
    logic is_rtc;
    logic bad_form;

    always_comb begin
        in_range = ({1'b0, idx} < 9'(REG_COUNT));
        is_rtc   = (idx <= 8'(RTC_LAST_IDX));
        bad_form = (rd && wr) || (size != '0) || (off > OFF_W'(1));
        if (!(rd || wr)) begin
            kind = ACC_IDLE;
        end else if (bad_form) begin
            kind = ACC_FAULT;
        end else if (off == '0) begin
            kind = rd ? ACC_IDX_RD : ACC_IDX_WR;
        end else if (!in_range) begin
            kind = ACC_FAULT;
        end else if (is_rtc) begin
            kind = rd ? ACC_RTC_RD : ACC_RTC_WR;
        end else begin
            kind = rd ? ACC_NV_RD : ACC_NV_WR;
        end
    end
endmodule

// File: rtl/cmos_nvram.sv
module cmos_nvram #(
    parameter int unsigned DEPTH = 114,
    parameter int unsigned AW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];
    logic       addr_ok;

    assign addr_ok = (int'(addr) < DEPTH);
    assign rdata   = addr_ok ? mem[addr] : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= 8'h00;
            end
        end else if (we && addr_ok) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/cmos_port.sv
module cmos_port
    import cmos_port_pkg::*;
#(
    parameter int unsigned REG_COUNT = 128,
    parameter int unsigned OFF_W     = 2,
    parameter int unsigned SIZE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_err,
    output logic [7:0]        rtc_idx,
    input  logic [7:0]        rtc_rdata,
    output logic [7:0]        rtc_wdata,
    output logic              rtc_wr
);
    localparam int unsigned NV_DEPTH = REG_COUNT - NV_BASE;
    localparam int unsigned NV_AW    = (NV_DEPTH > 1) ? $clog2(NV_DEPTH) : 1;

    acc_e              kind;
    acc_e              st_q;
    logic [7:0]        idx_q;
    logic [7:0]        cap_q;
    logic [7:0]        nv_rdata;
    logic [7:0]        idx_off;
    logic [NV_AW-1:0]  nv_addr;

    cmos_decode #(
        .OFF_W(OFF_W), .SIZE_W(SIZE_W), .REG_COUNT(REG_COUNT)
    ) dec_i (
        .rd(bus_rd), .wr(bus_wr), .off(bus_off), .size(bus_size),
        .idx(idx_q), .kind(kind)
    );

    assign idx_off = idx_q - 8'(NV_BASE);
    assign nv_addr = idx_off[NV_AW-1:0];

    cmos_nvram #(.DEPTH(NV_DEPTH), .AW(NV_AW)) nv_i (
        .clk(clk), .rst_n(rst_n), .we(kind == ACC_NV_WR),
        .addr(nv_addr), .wdata(bus_wdata), .rdata(nv_rdata)
    );

    // Index latch: only a clean byte write at offset 0 reloads it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (kind == ACC_IDX_WR) begin
            idx_q <= bus_wdata;
        end
    end

    // State register: each edge records the kind of access just seen,
    // together with the byte a read state will present.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ACC_IDLE;
            cap_q <= 8'h00;
        end else begin
            st_q <= kind;
            unique case (kind)
                ACC_IDX_RD: cap_q <= idx_q;
                ACC_RTC_RD: cap_q <= rtc_rdata;
                ACC_NV_RD:  cap_q <= nv_rdata;
                default:    cap_q <= 8'h00;
            endcase
        end
    end

    // Output process: decode of the registered state.
    always_comb begin
        bus_rdata = 8'h00;
        bus_err   = 1'b0;
        unique case (st_q)
            ACC_IDX_RD, ACC_RTC_RD, ACC_NV_RD: bus_rdata = cap_q;
            ACC_FAULT:                         bus_err   = 1'b1;
            default: ;
        endcase
    end

    assign rtc_idx   = idx_q;
    assign rtc_wdata = bus_wdata;
    assign rtc_wr    = (kind == ACC_RTC_WR);
endmodule

// File: rtl/cmos_port_chk.sv
module cmos_port_chk #(
    parameter int unsigned REG_COUNT = 128,
    parameter int unsigned OFF_W     = 2,
    parameter int unsigned SIZE_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  bus_off,
    input logic [SIZE_W-1:0] bus_size,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              bus_err,
    input logic [7:0]        rtc_idx,
    input logic [7:0]        rtc_rdata,
    input logic [7:0]        rtc_wdata,
    input logic              rtc_wr
);
    logic clean_idx_wr;
    logic clean_idx_rd;
    logic clean_dat_rd;

    assign clean_idx_wr = bus_wr && !bus_rd && bus_off == '0 && bus_size == '0;
    assign clean_idx_rd = bus_rd && !bus_wr && bus_off == '0 && bus_size == '0;
    assign clean_dat_rd = bus_rd && !bus_wr && bus_off == OFF_W'(1) && bus_size == '0;

    assert_wide_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && bus_size != '0 |=> bus_err);

    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clean_idx_wr |=> $stable(rtc_idx));

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clean_idx_wr |=> rtc_idx == $past(bus_wdata));

    assert_idx_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clean_idx_rd |=> bus_rdata == $past(rtc_idx) && !bus_err);

    assert_rtc_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_wr |-> bus_wr && !bus_rd && bus_off == OFF_W'(1) && bus_size == '0
                   && rtc_idx <= 8'd13 && rtc_wdata == bus_wdata);

    assert_rtc_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clean_dat_rd && rtc_idx <= 8'd13 |=> bus_rdata == $past(rtc_rdata) && !bus_err);

    assert_off_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && bus_off > OFF_W'(1) |=> bus_err && bus_rdata == 8'h00);

    assert_range_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && bus_off == OFF_W'(1) && int'(rtc_idx) >= REG_COUNT
        |=> bus_err && bus_rdata == 8'h00);

    assert_both_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_wr |=> bus_err);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !bus_err && bus_rdata == 8'h00);
endmodule

bind cmos_port cmos_port_chk #(
    .REG_COUNT(REG_COUNT), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
) chk_i (.*);

// File: tb/cmos_port_tb_top.sv
`timescale 1ns/1ps
module cmos_port_tb_top;
    localparam int RC = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_off = '0;
    logic [1:0] bus_size = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_err;
    logic [7:0] rtc_idx;
    logic [7:0] rtc_rdata;
    logic [7:0] rtc_wdata;
    logic       rtc_wr;

    int total = 0;
    int bad = 0;

    logic [7:0] rtc_mem [14];
    logic [7:0] rtc_exp [14];
    logic [7:0] nv_exp  [256];

    always #2 clk = ~clk;

    cmos_port #(.REG_COUNT(RC), .OFF_W(2), .SIZE_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .rtc_idx(rtc_idx),
        .rtc_rdata(rtc_rdata), .rtc_wdata(rtc_wdata), .rtc_wr(rtc_wr)
    );

    // Behavioural clock-block register file on the RTC side.
    assign rtc_rdata = (rtc_idx < 8'd14) ? rtc_mem[rtc_idx[3:0]] : 8'hEE;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 14; k++) rtc_mem[k] <= 8'(8'hA0 + k);
        end else if (rtc_wr && rtc_idx < 8'd14) begin
            rtc_mem[rtc_idx[3:0]] <= rtc_wdata;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic rd, input logic wr, input logic [1:0] off,
                       input logic [1:0] size, input logic [7:0] wd,
                       output logic [7:0] rdat, output logic err, output logic saw_wr);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_off = off; bus_size = size; bus_wdata = wd;
        #1 saw_wr = rtc_wr;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_off = '0; bus_size = '0;
        rdat = bus_rdata; err = bus_err;
    endtask

    function automatic logic [7:0] expect_data(input int i);
        if (i < 14) return rtc_exp[i];
        if (i < RC) return nv_exp[i];
        return 8'h00;
    endfunction

    logic [7:0] rd_v;
    logic       er_v;
    logic       sw_v;

    initial begin
        for (int k = 0; k < 14; k++) rtc_exp[k] = 8'(8'hA0 + k);
        for (int k = 0; k < 256; k++) nv_exp[k] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R9 rdata", bus_rdata, 8'h00);
        chk("R9 err", {7'd0, bus_err}, 8'h00);
        chk("R9 index", rtc_idx, 8'h00);
        rst_n = 1'b1;
        acc(1, 0, 2'd0, 2'd0, 8'h00, rd_v, er_v, sw_v);
        chk("R3 R9 index readback", rd_v, 8'h00);

        // Reset contents of local storage, and RTC reads.
        for (int i = 0; i < RC; i++) begin
            acc(0, 1, 2'd0, 2'd0, 8'(i), rd_v, er_v, sw_v);
            acc(1, 0, 2'd1, 2'd0, 8'h00, rd_v, er_v, sw_v);
            chk(i < 14 ? "R4 rtc read" : "R9 storage cleared", rd_v, expect_data(i));
        end

        // Write sweep over every index value.
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 5) & 255);
            acc(0, 1, 2'd0, 2'd0, 8'(i), rd_v, er_v, sw_v);
            chk("R2 index write no err", {7'd0, er_v}, 8'h00);
            chk("R2 index loaded", rtc_idx, 8'(i));
            acc(0, 1, 2'd1, 2'd0, v, rd_v, er_v, sw_v);
            if (i < 14) begin
                chk("R4 rtc_wr pulse", {7'd0, sw_v}, 8'h01);
                rtc_exp[i] = v;
            end else begin
                chk("R4 R5 no rtc_wr", {7'd0, sw_v}, 8'h00);
                if (i < RC) nv_exp[i] = v;
            end
            chk(i < RC ? "R5 write err" : "R7 range err", {7'd0, er_v}, (i < RC) ? 8'h00 : 8'h01);
            chk("R2 index kept after data write", rtc_idx, 8'(i));
        end

        // Read-back sweep.
        for (int i = 0; i < 256; i++) begin
            acc(0, 1, 2'd0, 2'd0, 8'(i), rd_v, er_v, sw_v);
            acc(1, 0, 2'd0, 2'd0, 8'h00, rd_v, er_v, sw_v);
            chk("R3 index read", rd_v, 8'(i));
            acc(1, 0, 2'd1, 2'd0, 8'h00, rd_v, er_v, sw_v);
            chk(i < 14 ? "R4 read" : (i < RC ? "R5 read" : "R7 read zero"), rd_v, expect_data(i));
            chk(i < RC ? "R5 read err" : "R7 read err", {7'd0, er_v}, (i < RC) ? 8'h01 & 8'(i >= RC) : 8'h01);
            acc(1, 0, 2'd1, 2'd0, 8'h00, rd_v, er_v, sw_v);
            chk("R2 repeat data read", rd_v, expect_data(i));
        end

        // Wide accesses.
        acc(0, 1, 2'd0, 2'd0, 8'd20, rd_v, er_v, sw_v);
        for (int s = 1; s < 4; s++) begin
            for (int o = 0; o < 2; o++) begin
                acc(0, 1, 2'(o), 2'(s), 8'h55, rd_v, er_v, sw_v);
                chk("R1 wide write err", {7'd0, er_v}, 8'h01);
                acc(1, 0, 2'(o), 2'(s), 8'h00, rd_v, er_v, sw_v);
                chk("R1 wide read err", {7'd0, er_v}, 8'h01);
                chk("R1 wide read zero", rd_v, 8'h00);
            end
        end
        chk("R1 index unchanged", rtc_idx, 8'd20);
        acc(1, 0, 2'd1, 2'd0, 8'h00, rd_v, er_v, sw_v);
        chk("R1 data unchanged", rd_v, nv_exp[20]);

        // Unknown offsets.
        for (int o = 2; o < 4; o++) begin
            acc(0, 1, 2'(o), 2'd0, 8'h33, rd_v, er_v, sw_v);
            chk("R6 write err", {7'd0, er_v}, 8'h01);
            acc(1, 0, 2'(o), 2'd0, 8'h00, rd_v, er_v, sw_v);
            chk("R6 read err", {7'd0, er_v}, 8'h01);
            chk("R6 read zero", rd_v, 8'h00);
        end
        chk("R6 index unchanged", rtc_idx, 8'd20);
        acc(1, 0, 2'd1, 2'd0, 8'h00, rd_v, er_v, sw_v);
        chk("R6 data unchanged", rd_v, nv_exp[20]);

        // Read and write together.
        acc(1, 1, 2'd0, 2'd0, 8'h07, rd_v, er_v, sw_v);
        chk("R8 both at offset 0 err", {7'd0, er_v}, 8'h01);
        chk("R8 index unchanged", rtc_idx, 8'd20);
        acc(1, 1, 2'd1, 2'd0, 8'h99, rd_v, er_v, sw_v);
        chk("R8 both at offset 1 err", {7'd0, er_v}, 8'h01);
        acc(1, 0, 2'd1, 2'd0, 8'h00, rd_v, er_v, sw_v);
        chk("R8 data unchanged", rd_v, nv_exp[20]);

        // Idle cycle after a fault.
        acc(1, 1, 2'd1, 2'd0, 8'h00, rd_v, er_v, sw_v);
        @(negedge clk);
        chk("R10 idle err low", {7'd0, bus_err}, 8'h00);
        chk("R10 idle rdata zero", bus_rdata, 8'h00);

        // Index rewrite immediately followed by a data read.
        @(negedge clk);
        bus_wr = 1'b1; bus_off = 2'd0; bus_wdata = 8'd15;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_off = 2'd1;
        @(negedge clk);
        bus_rd = 1'b0; bus_off = 2'd0;
        chk("R2 R5 back-to-back read", bus_rdata, nv_exp[15]);
        @(negedge clk);
        bus_wr = 1'b1; bus_off = 2'd0; bus_wdata = 8'd3;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_off = 2'd1;
        @(negedge clk);
        bus_rd = 1'b0; bus_off = 2'd0;
        chk("R2 R4 back-to-back read", bus_rdata, rtc_exp[3]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule